// File: doc/BRIEF.md
# Signed Iterative Divider with Run-Time Width

This block divides one signed two's-complement operand by another and returns the quotient rounded toward zero. Each operation picks its own width, 32 or 64 bits, through a select input sampled together with the operands. Narrow operations read only the low half of each operand bus. They return a result that is zero-extended to the full bus.

Operands are taken on a start/ready handshake while the unit is idle. The magnitudes are divided by a restoring shift-subtract loop that yields one quotient bit per clock. The sign is applied afterwards and the result is truncated to the selected width. A single-cycle done pulse marks the registered quotient.

No operand pattern traps or raises a status. A zero divisor gives a zero quotient, and the unit skips the loop for it. The most negative value divided by minus one wraps back to the most negative value.

Top module: `sdiv_unit`

## Requirements
- R1: `wide_i` = 0 selects 32-bit operation, and only bits [31:0] of each operand are used. `wide_i` = 1 selects 64-bit operation. The select is sampled when the operands are accepted.
- R2: When the dividend and divisor have the same sign, the quotient is |dividend| / |divisor|, with the fraction discarded.
- R3: When the signs differ, the quotient is the negation of |dividend| / |divisor|, so the result truncates toward zero (-7 / 2 = -3).
- R4: A divisor of zero at the selected width gives a quotient of zero. `done_o` rises on the second clock edge after the accepting edge.
- R5: Only the low width bits of the exact result are returned. The most negative value divided by -1 returns the most negative value: 0x80000000 for 32 bits, 0x8000000000000000 for 64 bits.
- R6: In 32-bit operation, bits [63:32] of `quot_o` are zero when `done_o` is high.
- R7: `in_ready_o` is high only while idle. A `start_i` seen while busy is ignored and does not alter the running operation.
- R8: For a nonzero divisor, `done_o` rises on the edge that comes width+2 edges after the accepting edge. `done_o` is high for exactly one cycle per operation.
- R9: After a synchronous active-high reset, the unit is idle with `in_ready_o` high, `done_o` low and `quot_o` zero.
- R10: A start presented in the cycle where `done_o` is high is accepted, because the unit is idle in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Operand valid. Accepted when `in_ready_o` is high |
| in_ready_o | output | 1 | Unit idle and able to accept operands |
| wide_i | input | 1 | Width select: 0 = 32 bits, 1 = 64 bits |
| dividend_i | input | 64 | Signed dividend |
| divisor_i | input | 64 | Signed divisor |
| done_o | output | 1 | One-cycle pulse when `quot_o` is valid |
| quot_o | output | 64 | Quotient, held until the next completion |

## Verification
The completion pulse of one operation and the acceptance of the next one can fall in the same cycle, because the unit is already idle while `done_o` is high. The bench waits for the cycle where `done_o` is high and drives a fresh start in that same cycle. It then checks two things: the finished quotient is correct, and the new operation produces its own correct result at the expected latency. A start driven while the unit is still running is also checked: `in_ready_o` must be low, and the running result must not change.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int unsigned FULL_W = 64;
  localparam int unsigned HALF_W = FULL_W / 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_prep.sv
// Operand conditioning: width extension, sign capture, magnitude, zero test.
module sdiv_prep #(
  parameter int unsigned W = 64
) (
  input  logic         wide,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] num_mag,
  output logic [W-1:0] den_mag,
  output logic         neg,
  output logic         den_zero
);
  localparam int unsigned NW = W / 2;

  logic [W-1:0] num_x, den_x;

  always_comb begin
    num_x = wide ? num : {{NW{num[NW-1]}}, num[NW-1:0]};
    den_x = wide ? den : {{NW{den[NW-1]}}, den[NW-1:0]};
    // magnitude of the most negative value is representable as unsigned
    num_mag  = num_x[W-1] ? (~num_x + 1'b1) : num_x;
    den_mag  = den_x[W-1] ? (~den_x + 1'b1) : den_x;
    neg      = num_x[W-1] ^ den_x[W-1];
    den_zero = (den_x == '0);
  end
endmodule

// File: rtl/sdiv_iter.sv
// Restoring shift-subtract datapath: one quotient bit per step.
module sdiv_iter #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic         wide,
  input  logic [W-1:0] num_mag,
  input  logic [W-1:0] den_mag,
  output logic [W-1:0] quo
);
  localparam int unsigned NW = W / 2;

  logic [W-1:0] rem_q, den_q, quo_q;
  logic [W:0]   trial;
  logic [W:0]   shifted;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      den_q <= den_mag;
      // narrow magnitudes are left-aligned so the loop always walks the MSB
      quo_q <= wide ? num_mag : (num_mag << NW);
    end else if (step) begin
      if (!trial[W]) begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
    end
  end

  assign quo = quo_q;

  // R2: partial remainder stays below the divisor after every step
  p_rem_below_div_r2: assert property (@(posedge clk) disable iff (rst)
    step |=> (rem_q < den_q));
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  output logic        in_ready_o,
  input  logic        wide_i,
  input  logic [63:0] dividend_i,
  input  logic [63:0] divisor_i,
  output logic        done_o,
  output logic [63:0] quot_o
);
  import sdiv_pkg::*;

  localparam int unsigned W  = FULL_W;
  localparam int unsigned NW = HALF_W;
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST_WIDE = CW'(W - 1);
  localparam logic [CW-1:0] LAST_NARW = CW'(NW - 1);

  sdiv_state_e  state_q;
  logic [CW-1:0] cnt_q;
  logic         neg_q, wide_q, zero_q;
  logic         accept, step;
  logic [W-1:0] num_mag, den_mag, quo_raw, quo_signed, quo_final;
  logic         neg_c, zero_c;

  assign in_ready_o = (state_q == ST_IDLE);
  assign accept     = start_i && in_ready_o;
  assign step       = (state_q == ST_RUN);

  sdiv_prep #(.W(W)) u_prep (
    .wide     (wide_i),
    .num      (dividend_i),
    .den      (divisor_i),
    .num_mag  (num_mag),
    .den_mag  (den_mag),
    .neg      (neg_c),
    .den_zero (zero_c)
  );

  sdiv_iter #(.W(W)) u_iter (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .step    (step),
    .wide    (wide_i),
    .num_mag (num_mag),
    .den_mag (den_mag),
    .quo     (quo_raw)
  );

  always_comb begin
    quo_signed = neg_q ? (~quo_raw + 1'b1) : quo_raw;
    quo_final  = wide_q ? quo_signed : {{NW{1'b0}}, quo_signed[NW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      neg_q   <= 1'b0;
      wide_q  <= 1'b0;
      zero_q  <= 1'b0;
      done_o  <= 1'b0;
      quot_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          neg_q   <= neg_c;
          wide_q  <= wide_i;
          zero_q  <= zero_c;
          cnt_q   <= wide_i ? LAST_WIDE : LAST_NARW;
          state_q <= zero_c ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          if (cnt_q == '0) state_q <= ST_FIN;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_FIN: begin
          done_o  <= 1'b1;
          quot_o  <= zero_q ? '0 : quo_final;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7: once operands are taken the unit stops offering ready
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready_o);

  // R4: zero divisor completes two edges after acceptance with a zero quotient
  p_zero_div_fast_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && zero_c) |=> ##1 (done_o && quot_o == '0));

  // R6: narrow results leave the upper half clear
  p_narrow_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && !wide_q) |-> (quot_o[W-1:NW] == '0));

  // R10: a start during the done pulse is taken
  p_accept_on_done_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i) |-> in_ready_o);
endmodule

// File: tb/sdiv_unit_bench.sv
module sdiv_unit_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [63:0] dividend_i = '0;
  logic [63:0] divisor_i = '0;
  logic        in_ready_o, done_o;
  logic [63:0] quot_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdiv_unit u_sdiv_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .in_ready_o(in_ready_o),
    .wide_i(wide_i), .dividend_i(dividend_i), .divisor_i(divisor_i),
    .done_o(done_o), .quot_o(quot_o)
  );

  localparam logic         VW [NVEC] = '{0,0,0,0,0,0,0,1,1,1,1,1,1,0};
  localparam logic [63:0]  VA [NVEC] = '{
    64'd100, 64'hFFFFFFF9, 64'd7, 64'hFFFFFFF9, 64'h80000000, 64'd5,
    64'hDEADBEEF_0000000C, 64'd1000000000000, 64'hFFFFFFFF_FFFFFFFF,
    64'h80000000_00000000, 64'd5, 64'd3, 64'hFFFFFFFF_FFFFFFF7, 64'd77};
  localparam logic [63:0]  VB [NVEC] = '{
    64'd7, 64'd2, 64'hFFFFFFFE, 64'hFFFFFFFE, 64'hFFFFFFFF, 64'd0,
    64'h12345678_00000003, 64'd1000, 64'd1,
    64'hFFFFFFFF_FFFFFFFF, 64'd0, 64'd7, 64'd4, 64'hFFFFFFFF_00000000};
  localparam logic [63:0]  VQ [NVEC] = '{
    64'd14, 64'hFFFFFFFD, 64'hFFFFFFFD, 64'd3, 64'h80000000, 64'd0,
    64'd4, 64'd1000000000, 64'hFFFFFFFF_FFFFFFFF,
    64'h80000000_00000000, 64'd0, 64'd0, 64'hFFFFFFFF_FFFFFFFE, 64'd0};
  localparam string        VT [NVEC] = '{
    "R2", "R3", "R3", "R2", "R5", "R4", "R1", "R1", "R3",
    "R5", "R4", "R2", "R3", "R1"};

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_q(input logic w, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] ax, bx, ma, mb, q;
    ax = w ? a : {{32{a[31]}}, a[31:0]};
    bx = w ? b : {{32{b[31]}}, b[31:0]};
    if (bx == 0) return 64'd0;
    ma = ax[63] ? -ax : ax;
    mb = bx[63] ? -bx : bx;
    q  = ma / mb;
    if (ax[63] ^ bx[63]) q = -q;
    if (!w) q = {32'd0, q[31:0]};
    return q;
  endfunction

  function automatic int exp_lat(input logic w, input logic [63:0] b);
    if ((w ? b : {32'd0, b[31:0]}) == 0) return 2;
    return w ? 66 : 34;
  endfunction

  // called at a negedge with the unit idle
  task automatic run_op(input logic w, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] exp, input string req);
    int n;
    check(in_ready_o == 1'b1, "R7", {63'd0, in_ready_o}, 64'd1);
    start_i = 1; wide_i = w; dividend_i = a; divisor_i = b;
    @(posedge clk);
    @(negedge clk);
    start_i = 0;
    n = 1;
    while (!done_o && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(quot_o == exp, req, quot_o, exp);
    check(n == exp_lat(w, b), (exp_lat(w, b) == 2) ? "R4" : "R8",
          64'(n), 64'(exp_lat(w, b)));
    @(negedge clk);
    check(done_o == 1'b0, "R8", {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    logic [63:0] s;
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    check(in_ready_o == 1'b1, "R9", {63'd0, in_ready_o}, 64'd1);
    check(done_o == 1'b0, "R9", {63'd0, done_o}, 64'd0);
    check(quot_o == 64'd0, "R9", quot_o, 64'd0);

    for (int i = 0; i < NVEC; i++) run_op(VW[i], VA[i], VB[i], VQ[i], VT[i]);

    // model-checked operand sweep
    s = 64'h9E3779B97F4A7C15;
    for (int i = 0; i < 24; i++) begin
      logic [63:0] a, b;
      logic w;
      s = s ^ (s << 13); s = s ^ (s >> 7); a = s;
      s = s ^ (s << 13); s = s ^ (s >> 7); b = s >> (i % 40);
      w = i[0];
      run_op(w, a, b, ref_q(w, a, b), w ? "R2" : "R1");
    end

    // R7: start while busy is ignored
    start_i = 1; wide_i = 0; dividend_i = 64'd1000; divisor_i = 64'd10;
    @(posedge clk); @(negedge clk);
    start_i = 0;
    repeat (5) @(negedge clk);
    check(in_ready_o == 1'b0, "R7", {63'd0, in_ready_o}, 64'd0);
    start_i = 1; dividend_i = 64'd9; divisor_i = 64'd3; wide_i = 1;
    @(negedge clk);
    start_i = 0;
    n = 0;
    while (!done_o && n < 300) begin @(negedge clk); n++; end
    check(quot_o == 64'd100, "R7", quot_o, 64'd100);
    @(negedge clk);

    // R10: start during done pulse is accepted (zero divisor first, then real op)
    start_i = 1; wide_i = 0; dividend_i = 64'd8; divisor_i = 64'd0;
    @(posedge clk); @(negedge clk);
    start_i = 0;
    @(negedge clk);
    check(done_o == 1'b1, "R4", {63'd0, done_o}, 64'd1);
    check(in_ready_o == 1'b1, "R10", {63'd0, in_ready_o}, 64'd1);
    start_i = 1; wide_i = 1; dividend_i = -64'sd21; divisor_i = 64'd5;
    @(posedge clk); @(negedge clk);
    start_i = 0;
    n = 1;
    while (!done_o && n < 300) begin @(negedge clk); n++; end
    check(quot_o == 64'hFFFFFFFF_FFFFFFFC, "R10", quot_o, 64'hFFFFFFFF_FFFFFFFC);
    check(n == 66, "R10", 64'(n), 64'd66);
    @(negedge clk);

    // R9: reset mid-operation returns to idle
    start_i = 1; wide_i = 1; dividend_i = 64'd50; divisor_i = 64'd5;
    @(posedge clk); @(negedge clk);
    start_i = 0;
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(in_ready_o == 1'b1, "R9", {63'd0, in_ready_o}, 64'd1);
    check(done_o == 1'b0, "R9", {63'd0, done_o}, 64'd0);
    check(quot_o == 64'd0, "R9", quot_o, 64'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule